// File: doc/BRIEF.md
# Edge-Triggered Phase Error Detector

This block measures how far a locally generated square wave trails a reference square wave, in ticks of a fast system clock. Both one-bit inputs are first brought through two-flop synchronizers. A rising edge on the reference sets an internal flag, and a rising edge on the local wave clears it. The flag therefore reacts only to transitions, never to levels, in the manner of a JK flip-flop. A counter advances once per clock while the flag is high.

On every reference rising edge, the counter value is captured into an unsigned error word and the counter restarts from zero. A one-cycle strobe marks each new word. Because the error depends only on edge spacing, the loop that uses this detector settles with the local wave trailing by half a period. At that point the error word equals half the reference period measured in clock ticks.

For comparison, an XOR of the two synchronized inputs is also provided. This is the classic level-sensitive detector, which settles at a quarter-period offset and covers only a plus or minus 90 degree range. The clock is meant to run many times faster than the reference, for example 8, 16 or 32 times. Both inputs must be synchronous to that clock.

Top module: `phase_err_detector`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `phase_err` is 0 and `err_valid`, `flag_out` and `xor_out` are 0.
- R2: A rising edge on `ref_in` alone drives `flag_out` to 1. A rising edge on `loc_in` alone drives it to 0. A rising edge means the synchronized signal is 0 on one sample and 1 on the next. Falling edges and steady levels leave `flag_out` unchanged.
- R3: When rising edges of `ref_in` and `loc_in` are detected in the same cycle, `flag_out` inverts.
- R4: On each detected `ref_in` rising edge, `phase_err` takes the counter value held just before that edge and the counter restarts at 0. `phase_err` holds its value until the next such edge.
- R5: `err_valid` is 1 for exactly the one cycle in which a new `phase_err` value first appears, and 0 otherwise.
- R6: The counter adds one per clock while `flag_out` is 1 and holds while it is 0. It stops at 2^CNT_W-1 rather than wrapping.
- R7: A rising edge on an input takes effect two clocks after it is first sampled. If the input is first seen high at clock edge k, having been low at edge k-1, then `flag_out` and `phase_err` change at edge k+2.
- R8: `xor_out` is the XOR of the two inputs as sampled two clock edges earlier.
- R9: For periodic inputs where `loc_in` lags `ref_in` by L clocks, with L below the period and below 2^CNT_W-1, every `phase_err` word after the first two equals L. A half-period lag gives half the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference square wave |
| loc_in | input | 1 | Locally generated square wave |
| phase_err | output | CNT_W | Latched phase error, in clock ticks |
| err_valid | output | 1 | One-cycle strobe marking a new phase_err |
| flag_out | output | 1 | Edge-driven set/reset flag |
| xor_out | output | 1 | XOR detector output |

## Verification
The assertions assume that both inputs change only on clock boundaries. Under that assumption, two reference rising edges can never be detected in back-to-back cycles, so a single-cycle strobe is always followed by a quiet cycle. The stimulus changes the inputs only at the falling clock edge. It holds every level for at least one full clock, whether it is running periodic waves or random segments, so the one-sample-low, one-sample-high edge definition always applies. Phase lags are chosen to cover:
- a quarter-period lag;
- a half-period lag, which is the lock point;
- coincident edges;
- a lag longer than the counter can hold.

// File: rtl/phase_err_detector.sv
module phase_err_detector #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             loc_in,
  output logic [CNT_W-1:0] phase_err,
  output logic             err_valid,
  output logic             flag_out,
  output logic             xor_out
);

  localparam int SYNC_D = 3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_D-1:0] ref_sh, loc_sh;
  logic              ref_rise, loc_rise;
  logic              flag_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sh <= '0;
      loc_sh <= '0;
    end else begin
      ref_sh <= {ref_sh[SYNC_D-2:0], ref_in};
      loc_sh <= {loc_sh[SYNC_D-2:0], loc_in};
    end
  end

  assign ref_rise = ref_sh[1] & ~ref_sh[2];
  assign loc_rise = loc_sh[1] & ~loc_sh[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else
      case ({ref_rise, loc_rise})
        2'b11:   flag_q <= ~flag_q;
        2'b10:   flag_q <= 1'b1;
        2'b01:   flag_q <= 1'b0;
        default: flag_q <= flag_q;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      phase_err <= '0;
      err_valid <= 1'b0;
    end else begin
      err_valid <= ref_rise;
      if (ref_rise) begin
        phase_err <= cnt_q;
        cnt_q     <= '0;
      end else if (flag_q && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign flag_out = flag_q;
  assign xor_out  = ref_sh[1] ^ loc_sh[1];

endmodule

// File: rtl/phase_err_detector_chk.sv
module phase_err_detector_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_rise,
  input logic             loc_rise,
  input logic             flag_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] phase_err,
  input logic             err_valid
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !loc_rise) |=> flag_q);

  a_r2_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_rise && !ref_rise) |=> !flag_q);

  a_r3_flag_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && loc_rise) |=> (flag_q != $past(flag_q)));

  a_r4_latch_value: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> (phase_err == $past(cnt_q) && cnt_q == '0));

  a_r4_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_rise |=> $stable(phase_err));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid);

  a_r6_hold_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !ref_rise) |=> $stable(cnt_q));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !ref_rise) |=> cnt_q == CNT_MAX);

endmodule

bind phase_err_detector phase_err_detector_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .ref_rise(ref_rise),
  .loc_rise(loc_rise),
  .flag_q(flag_q),
  .cnt_q(cnt_q),
  .phase_err(phase_err),
  .err_valid(err_valid)
);

// File: tb/phase_err_detector_tb.sv
module phase_err_detector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int MAXV = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic loc_in = 1'b0;
  logic [CNT_W-1:0] phase_err;
  logic err_valid, flag_out, xor_out;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  phase_err_detector #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .loc_in(loc_in),
    .phase_err(phase_err), .err_valid(err_valid),
    .flag_out(flag_out), .xor_out(xor_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit qr[$];
  bit ql[$];
  int m_cnt, m_err;
  bit m_flag, m_valid, m_xor;

  function automatic bit hist(ref bit q[$], input int i);
    return (q.size() > i) ? q[i] : 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qr.delete(); ql.delete();
      m_cnt = 0; m_err = 0; m_flag = 0; m_valid = 0; m_xor = 0;
    end else begin
      bit rr, lr;
      qr.push_front(ref_in);
      ql.push_front(loc_in);
      if (qr.size() > 4) void'(qr.pop_back());
      if (ql.size() > 4) void'(ql.pop_back());
      rr = hist(qr, 2) && !hist(qr, 3);
      lr = hist(ql, 2) && !hist(ql, 3);
      m_valid = rr;
      if (rr) begin
        m_err = m_cnt;
        m_cnt = 0;
      end else if (m_flag && m_cnt < MAXV) begin
        m_cnt++;
      end
      if (rr && lr) m_flag = !m_flag;
      else if (rr) m_flag = 1;
      else if (lr) m_flag = 0;
      m_xor = hist(qr, 1) ^ hist(ql, 1);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
    end
  endtask

  // per-clock comparison against the model
  int exp_lag = -1;
  int valid_seen = 0;
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check("R4/R7 phase_err", int'(phase_err), m_err);
      check("R5 err_valid", int'(err_valid), int'(m_valid));
      check("R2/R3/R7 flag_out", int'(flag_out), int'(m_flag));
      check("R8 xor_out", int'(xor_out), int'(m_xor));
      check("R6 saturation bound", int'(phase_err <= MAXV), 1);
      if (err_valid) begin
        valid_seen++;
        if (exp_lag >= 0 && valid_seen > 2)
          check("R9 lag word", int'(phase_err), exp_lag);
      end
    end
  end

  task automatic run_waves(input int period, input int lag, input int n_per, input int exp);
    valid_seen = 0;
    exp_lag = exp;
    for (int t = 0; t < period * n_per; t++) begin
      @(negedge clk);
      ref_in = (t % period) < period / 2;
      loc_in = ((t - lag + period * 64) % period) < period / 2;
    end
    exp_lag = -1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 phase_err", int'(phase_err), 0);
    check("R1 err_valid", int'(err_valid), 0);
    check("R1 flag_out", int'(flag_out), 0);
    check("R1 xor_out", int'(xor_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag after release", int'(flag_out), 0);

    run_waves(64, 32, 20, 32);   // R9 half-period lag
    run_waves(64, 10, 20, 10);   // R9 short lag
    run_waves(32, 20, 20, 20);   // R9 long lag
    run_waves(40, 0, 20, -1);    // R3 coincident edges
    run_waves(800, 700, 6, MAXV); // R6 saturation
    run_waves(24, 6, 20, 6);

    // random segments, R2 levels and falling edges have no effect
    for (int s = 0; s < 600; s++) begin
      int len;
      len = 1 + int'($urandom_range(5));
      ref_in = 1'($urandom_range(1));
      loc_in = 1'($urandom_range(1));
      repeat (len) @(negedge clk);
    end

    // reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 phase_err after reset", int'(phase_err), 0);
    check("R1 flag after reset", int'(flag_out), 0);
    rst_n = 1'b1;
    run_waves(48, 24, 10, 24);
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected finished", cycles);
    finish_run();
  end

endmodule